// File: doc/BRIEF.md
# Bus Cycle Sideband Sampling Tracker

This block follows one processor bus transaction at a time. The transaction runs from the clock in which the address strobe is accepted to the data-ready beat that finishes it. Inside that window it decides which clocks count as sampling points for the cache-enable, write-policy and parity-enable sideband inputs. It also holds the transaction's attribute outputs: lock, memory/IO, cache-disable and write-through.

The number of data beats the tracker expects depends on the transaction type. A single transfer takes one beat, a burst takes four, and an interrupt-acknowledge takes two. The cache-enable and write-policy levels are latched at the earliest legal point: either a next-address indication or the first data beat. Every data beat of a read launches a parity-check strobe two clocks later. The strobe carries the parity-enable level that belongs to that beat.

Top module: `bcyc_sideband_tracker`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `busy_o`, `lock_o`, `mio_o`, `pcd_o`, `pwt_o`, `cache_en_o`, `wpolicy_o`, `pchk_o` and `pchk_pen_o` are all 0 and the tracker is idle.
- R2: An accepted strobe makes `busy_o` 1, and `lock_o`, `mio_o`, `pcd_o` and `pwt_o` follow the strobe's attribute inputs from the next clock. These outputs hold until the clock after the final data beat, when all of them return to 0.
- R3: The transaction ends on its final data beat. That is beat 1 for a single transfer, beat 4 when `attr_burst_i` is 1, and beat 2 when `attr_inta_i` is 1 and `attr_burst_i` is 0.
- R4: An address strobe that arrives while a transaction is in progress has no effect on the attribute outputs or on the beat count.
- R5: On a read (`attr_write_i` = 0), `cache_en_o` takes the value of `cache_en_i` at whichever comes first: an honoured next-address clock or the first data beat. On a write, `cache_en_o` stays 0.
- R6: Next-address (`nxt_addr_i`) is honoured only from the clock after the strobe up to the first data beat. Outside that window it captures nothing.
- R7: An accepted strobe clears `cache_en_o` and `wpolicy_o` to 0. After capture they hold until the next accepted strobe, even across later beats and idle clocks.
- R8: `wpolicy_o` (1 = write-through) is captured from `wpolicy_i` at the same point as cache-enable, on both reads and writes.
- R9: `pchk_o` pulses for one clock exactly two clocks after each data beat of a read. Write beats and idle clocks produce no pulse.
- R10: `pchk_pen_o` carries the `par_en_i` level of the beat that caused the pulse. In an interrupt-acknowledge it is 0 for the first beat and carries `par_en_i` only for the second beat.
- R11: Between two consecutive locked transactions, `lock_o` is 0 for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Address strobe |
| attr_write_i | input | 1 | 1 = write transaction |
| attr_lock_i | input | 1 | Locked transaction |
| attr_burst_i | input | 1 | Four-beat burst |
| attr_inta_i | input | 1 | Interrupt-acknowledge (read, two beats) |
| attr_mio_i | input | 1 | 1 = memory, 0 = IO |
| attr_nocache_i | input | 1 | Page cache-disable attribute |
| attr_wthru_i | input | 1 | Page write-through attribute |
| rdy_i | input | 1 | Data-ready beat |
| nxt_addr_i | input | 1 | Next-address indication |
| cache_en_i | input | 1 | Cache-enable sideband |
| wpolicy_i | input | 1 | Write-policy sideband, 1 = write-through |
| par_en_i | input | 1 | Parity-enable sideband |
| busy_o | output | 1 | Transaction in progress |
| lock_o | output | 1 | Held lock |
| mio_o | output | 1 | Held memory/IO |
| pcd_o | output | 1 | Held cache-disable |
| pwt_o | output | 1 | Held write-through |
| cache_en_o | output | 1 | Latched cache-enable |
| wpolicy_o | output | 1 | Latched write-policy |
| pchk_o | output | 1 | Parity-check strobe |
| pchk_pen_o | output | 1 | Parity-enable qualifier for the strobe |

## Verification
The bench drives `cache_en_i` and `wpolicy_i` to the opposite of the intended value on every clock except the one legal capture point. It also raises next-address on the strobe clock, during later beats and while idle. A tracker with a badly placed capture window, or one that samples again later, therefore shows inverted latched values.

A stray strobe with flipped lock is issued mid-transaction. A tracker that accepts it would flip `lock_o` or restart its beat count and end early or late. Locked transactions are run back to back; a tracker that never drops lock between them would show `lock_o` high on the first idle clock.

A scoreboard pairs each read beat with the clock two cycles later. It catches pulses that come a clock off, pulses on write beats, and a parity-enable qualifier taken on the wrong beat of an interrupt-acknowledge.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

    localparam int unsigned SINGLE_BEATS_DEF = 1;
    localparam int unsigned BURST_BEATS_DEF  = 4;
    localparam int unsigned INTA_BEATS_DEF   = 2;
    localparam int unsigned INTA_PEN_BEAT_DEF = 2;
    localparam int unsigned PCHK_DELAY_DEF   = 2;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } cyc_state_e;

    typedef struct packed {
        logic write;
        logic lock;
        logic burst;
        logic inta;
        logic mio;
        logic nocache;
        logic wthru;
    } cyc_attr_t;

    typedef struct packed {
        logic vld;
        logic pen;
    } pchk_slot_t;

    function automatic int unsigned beats_for(input cyc_attr_t a,
                                              input int unsigned single_n,
                                              input int unsigned burst_n,
                                              input int unsigned inta_n);
        if (a.burst)
            return burst_n;
        else if (a.inta)
            return inta_n;
        else
            return single_n;
    endfunction

    function automatic logic is_read(input cyc_attr_t a);
        return !a.write;
    endfunction

endpackage

// File: rtl/bcyc_seq.sv
module bcyc_seq
    import bcyc_pkg::*;
#(
    parameter int unsigned SINGLE_BEATS = SINGLE_BEATS_DEF,
    parameter int unsigned BURST_BEATS  = BURST_BEATS_DEF,
    parameter int unsigned INTA_BEATS   = INTA_BEATS_DEF,
    parameter int unsigned BEAT_W       = $clog2(BURST_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  cyc_attr_t         attr_i,
    input  logic              rdy_i,
    output logic              active_o,
    output logic              start_o,
    output logic              last_o,
    output logic              first_win_o,
    output logic [BEAT_W-1:0] beat_idx_o,
    output cyc_attr_t         attr_q_o
);

    cyc_state_e        state_q;
    cyc_attr_t         attr_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beats_need;

    assign active_o    = (state_q == ST_ACTIVE);
    assign start_o     = !active_o && strobe_i;
    assign beats_need  = BEAT_W'(beats_for(attr_q, SINGLE_BEATS, BURST_BEATS, INTA_BEATS));
    assign last_o      = active_o && rdy_i && (beat_q == beats_need - BEAT_W'(1));
    assign first_win_o = active_o && (beat_q == '0);
    assign beat_idx_o  = beat_q;
    assign attr_q_o    = attr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            attr_q  <= '0;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (strobe_i) begin
                        state_q <= ST_ACTIVE;
                        attr_q  <= attr_i;
                        beat_q  <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (last_o) begin
                        state_q <= ST_IDLE;
                        beat_q  <= '0;
                    end else if (rdy_i) begin
                        beat_q  <= beat_q + BEAT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_beat_bound_R3: assert property (@(posedge clk) disable iff (rst)
        active_o |-> (beat_q < beats_need));

    assert_stray_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (active_o && strobe_i && !last_o) |=> (active_o && $stable(attr_q)));

    assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !active_o);

endmodule

// File: rtl/bcyc_capture.sv
module bcyc_capture
    import bcyc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      active_i,
    input  logic      first_win_i,
    input  cyc_attr_t attr_q_i,
    input  logic      rdy_i,
    input  logic      nxt_addr_i,
    input  logic      cache_en_i,
    input  logic      wpolicy_i,
    output logic      cache_en_o,
    output logic      wpolicy_o
);

    logic ken_q;
    logic wp_q;
    logic taken_q;
    logic take;

    assign take       = first_win_i && !taken_q && (nxt_addr_i || rdy_i);
    assign cache_en_o = ken_q;
    assign wpolicy_o  = wp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ken_q   <= 1'b0;
            wp_q    <= 1'b0;
            taken_q <= 1'b0;
        end else if (start_i) begin
            ken_q   <= 1'b0;
            wp_q    <= 1'b0;
            taken_q <= 1'b0;
        end else if (take) begin
            ken_q   <= is_read(attr_q_i) ? cache_en_i : 1'b0;
            wp_q    <= wpolicy_i;
            taken_q <= 1'b1;
        end
    end

    assert_write_no_ken_R5: assert property (@(posedge clk) disable iff (rst)
        (active_i && attr_q_i.write) |-> !ken_q);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!active_i && !start_i) |=> ($stable(ken_q) && $stable(wp_q)));

    assert_hold_after_take_R7: assert property (@(posedge clk) disable iff (rst)
        (taken_q && !start_i) |=> ($stable(ken_q) && $stable(wp_q)));

    assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!ken_q && !wp_q));

endmodule

// File: rtl/bcyc_parity.sv
module bcyc_parity
    import bcyc_pkg::*;
#(
    parameter int unsigned PCHK_DELAY    = PCHK_DELAY_DEF,
    parameter int unsigned INTA_PEN_BEAT = INTA_PEN_BEAT_DEF,
    parameter int unsigned BEAT_W        = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  cyc_attr_t         attr_q_i,
    input  logic              rdy_i,
    input  logic [BEAT_W-1:0] beat_idx_i,
    input  logic              par_en_i,
    output logic              pchk_o,
    output logic              pchk_pen_o
);

    localparam logic [BEAT_W-1:0] PEN_IDX = BEAT_W'(INTA_PEN_BEAT - 1);

    logic       rd_beat;
    logic       pen_ok;
    pchk_slot_t slot_q [PCHK_DELAY];

    assign rd_beat = active_i && is_read(attr_q_i) && rdy_i;
    assign pen_ok  = !attr_q_i.inta || (beat_idx_i == PEN_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q[0] <= '0;
        end else begin
            slot_q[0].vld <= rd_beat;
            slot_q[0].pen <= rd_beat && pen_ok && par_en_i;
        end
    end

    for (genvar k = 1; k < PCHK_DELAY; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[k] <= '0;
            else
                slot_q[k] <= slot_q[k-1];
        end

        assert_stage_chain_R9: assert property (@(posedge clk) disable iff (rst)
            slot_q[k].vld |-> $past(slot_q[k-1].vld));
    end

    assign pchk_o     = slot_q[PCHK_DELAY-1].vld;
    assign pchk_pen_o = slot_q[PCHK_DELAY-1].pen;

    assert_first_stage_R9: assert property (@(posedge clk) disable iff (rst)
        slot_q[0].vld |-> $past(rd_beat));

    assert_pen_qualified_R10: assert property (@(posedge clk) disable iff (rst)
        pchk_pen_o |-> pchk_o);

endmodule

// File: rtl/bcyc_sideband_tracker.sv
module bcyc_sideband_tracker
    import bcyc_pkg::*;
#(
    parameter int unsigned SINGLE_BEATS  = SINGLE_BEATS_DEF,
    parameter int unsigned BURST_BEATS   = BURST_BEATS_DEF,
    parameter int unsigned INTA_BEATS    = INTA_BEATS_DEF,
    parameter int unsigned INTA_PEN_BEAT = INTA_PEN_BEAT_DEF,
    parameter int unsigned PCHK_DELAY    = PCHK_DELAY_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic attr_write_i,
    input  logic attr_lock_i,
    input  logic attr_burst_i,
    input  logic attr_inta_i,
    input  logic attr_mio_i,
    input  logic attr_nocache_i,
    input  logic attr_wthru_i,
    input  logic rdy_i,
    input  logic nxt_addr_i,
    input  logic cache_en_i,
    input  logic wpolicy_i,
    input  logic par_en_i,
    output logic busy_o,
    output logic lock_o,
    output logic mio_o,
    output logic pcd_o,
    output logic pwt_o,
    output logic cache_en_o,
    output logic wpolicy_o,
    output logic pchk_o,
    output logic pchk_pen_o
);

    localparam int unsigned MAX_BEATS = (BURST_BEATS > INTA_BEATS) ? BURST_BEATS : INTA_BEATS;
    localparam int unsigned BEAT_W    = $clog2(MAX_BEATS + 1);

    cyc_attr_t         attr_in;
    cyc_attr_t         attr_q;
    logic              active;
    logic              start;
    logic              last;
    logic              first_win;
    logic [BEAT_W-1:0] beat_idx;

    always_comb begin
        attr_in         = '0;
        attr_in.write   = attr_write_i && !attr_inta_i;
        attr_in.lock    = attr_lock_i;
        attr_in.burst   = attr_burst_i;
        attr_in.inta    = attr_inta_i;
        attr_in.mio     = attr_mio_i;
        attr_in.nocache = attr_nocache_i;
        attr_in.wthru   = attr_wthru_i;
    end

    bcyc_seq #(
        .SINGLE_BEATS (SINGLE_BEATS),
        .BURST_BEATS  (MAX_BEATS == BURST_BEATS ? BURST_BEATS : BURST_BEATS),
        .INTA_BEATS   (INTA_BEATS),
        .BEAT_W       (BEAT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (strobe_i),
        .attr_i      (attr_in),
        .rdy_i       (rdy_i),
        .active_o    (active),
        .start_o     (start),
        .last_o      (last),
        .first_win_o (first_win),
        .beat_idx_o  (beat_idx),
        .attr_q_o    (attr_q)
    );

    bcyc_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .active_i    (active),
        .first_win_i (first_win),
        .attr_q_i    (attr_q),
        .rdy_i       (rdy_i),
        .nxt_addr_i  (nxt_addr_i),
        .cache_en_i  (cache_en_i),
        .wpolicy_i   (wpolicy_i),
        .cache_en_o  (cache_en_o),
        .wpolicy_o   (wpolicy_o)
    );

    bcyc_parity #(
        .PCHK_DELAY    (PCHK_DELAY),
        .INTA_PEN_BEAT (INTA_PEN_BEAT),
        .BEAT_W        (BEAT_W)
    ) u_par (
        .clk        (clk),
        .rst        (rst),
        .active_i   (active),
        .attr_q_i   (attr_q),
        .rdy_i      (rdy_i),
        .beat_idx_i (beat_idx),
        .par_en_i   (par_en_i),
        .pchk_o     (pchk_o),
        .pchk_pen_o (pchk_pen_o)
    );

    assign busy_o = active;
    assign lock_o = active && attr_q.lock;
    assign mio_o  = active && attr_q.mio;
    assign pcd_o  = active && attr_q.nocache;
    assign pwt_o  = active && attr_q.wthru;

    assert_lock_gap_R11: assert property (@(posedge clk) disable iff (rst)
        (start && attr_lock_i) |-> !lock_o);

    assert_attr_follow_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy_o && (lock_o == $past(attr_lock_i)) && (mio_o == $past(attr_mio_i))));

    assert_lock_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last) |=> $stable(lock_o));

    assert_write_no_pchk_R9: assert property (@(posedge clk) disable iff (rst)
        (active && attr_q.write) |=> !u_par.slot_q[0].vld);

endmodule

// File: tb/test_bcyc_sideband_tracker.sv
module test_bcyc_sideband_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct {
        int cyc;
        bit pen;
    } exp_t;

    logic clk = 1'b0;
    logic rst;
    logic strobe_i, attr_write_i, attr_lock_i, attr_burst_i, attr_inta_i;
    logic attr_mio_i, attr_nocache_i, attr_wthru_i;
    logic rdy_i, nxt_addr_i, cache_en_i, wpolicy_i, par_en_i;
    logic busy_o, lock_o, mio_o, pcd_o, pwt_o, cache_en_o, wpolicy_o, pchk_o, pchk_pen_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bcyc_sideband_tracker i_bcyc_sideband_tracker (
        .clk(clk), .rst(rst), .strobe_i(strobe_i),
        .attr_write_i(attr_write_i), .attr_lock_i(attr_lock_i),
        .attr_burst_i(attr_burst_i), .attr_inta_i(attr_inta_i),
        .attr_mio_i(attr_mio_i), .attr_nocache_i(attr_nocache_i),
        .attr_wthru_i(attr_wthru_i), .rdy_i(rdy_i), .nxt_addr_i(nxt_addr_i),
        .cache_en_i(cache_en_i), .wpolicy_i(wpolicy_i), .par_en_i(par_en_i),
        .busy_o(busy_o), .lock_o(lock_o), .mio_o(mio_o), .pcd_o(pcd_o),
        .pwt_o(pwt_o), .cache_en_o(cache_en_o), .wpolicy_o(wpolicy_o),
        .pchk_o(pchk_o), .pchk_pen_o(pchk_pen_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Monitor: scoreboard for parity-check strobes (R9, R10)
    always @(negedge clk) begin
        if (!rst) begin
            if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
                check("R9", "pchk_o on expected clock", pchk_o, 1'b1);
                check("R10", "pchk_pen_o", pchk_pen_o, sb_q[0].pen);
                void'(sb_q.pop_front());
            end else if (pchk_o !== 1'b0) begin
                check("R9", "unexpected pchk_o", pchk_o, 1'b0);
            end
        end
    end

    task automatic idle_inputs();
        strobe_i = 0; attr_write_i = 0; attr_lock_i = 0; attr_burst_i = 0;
        attr_inta_i = 0; attr_mio_i = 0; attr_nocache_i = 0; attr_wthru_i = 0;
        rdy_i = 0; nxt_addr_i = 0; cache_en_i = 0; wpolicy_i = 0; par_en_i = 0;
    endtask

    // Driver: one transaction; called right after a negedge
    task automatic run_cycle(input bit wr, input bit lk, input bit bu, input bit ia,
                             input int waits, input int na_wait, input bit ken,
                             input bit wp, input bit stray, input bit gap,
                             input logic [3:0] pens);
        int nb = bu ? 4 : (ia ? 2 : 1);
        bit rd = !wr || ia;
        bit exp_ken = rd && ken;
        strobe_i = 1; attr_write_i = wr; attr_lock_i = lk; attr_burst_i = bu;
        attr_inta_i = ia; attr_mio_i = !ia; attr_nocache_i = wr; attr_wthru_i = ken;
        rdy_i = 0; nxt_addr_i = 1; cache_en_i = !ken; wpolicy_i = !wp; par_en_i = 0;
        @(negedge clk);
        strobe_i = 0; nxt_addr_i = 0;
        check("R2", "busy_o after strobe", busy_o, 1'b1);
        check("R2", "lock_o after strobe", lock_o, lk);
        check("R2", "mio_o after strobe", mio_o, !ia);
        check("R2", "pcd_o after strobe", pcd_o, wr);
        check("R2", "pwt_o after strobe", pwt_o, ken);
        check("R7", "cache_en_o cleared by strobe", cache_en_o, 1'b0);
        check("R7", "wpolicy_o cleared by strobe", wpolicy_o, 1'b0);
        for (int w = 0; w < waits; w++) begin
            nxt_addr_i = (w == na_wait);
            cache_en_i = (w == na_wait) ? ken : !ken;
            wpolicy_i  = (w == na_wait) ? wp : !wp;
            if (stray && w == 0) begin
                strobe_i = 1; attr_lock_i = !lk; attr_burst_i = !bu;
            end
            @(negedge clk);
            strobe_i = 0; attr_lock_i = lk; attr_burst_i = bu; nxt_addr_i = 0;
            check("R4", "lock_o during wait", lock_o, lk);
            if (w == na_wait) begin
                check("R5", "cache_en_o after next-address", cache_en_o, exp_ken);
                check("R8", "wpolicy_o after next-address", wpolicy_o, wp);
            end
        end
        for (int b = 0; b < nb; b++) begin
            rdy_i = 1;
            nxt_addr_i = (b > 0);
            cache_en_i = (b == 0 && na_wait < 0) ? ken : !ken;
            wpolicy_i  = (b == 0 && na_wait < 0) ? wp : !wp;
            par_en_i = pens[b];
            if (rd) sb_q.push_back('{cyc: cyc + 2, pen: ia ? (b == 1 && pens[b]) : pens[b]});
            @(negedge clk);
            rdy_i = 0; nxt_addr_i = 0;
            if (b < nb - 1) begin
                check("R3", "busy_o before final beat", busy_o, 1'b1);
                check("R7", "cache_en_o held between beats", cache_en_o, exp_ken);
            end
        end
        check("R3", "busy_o after final beat", busy_o, 1'b0);
        check("R2", "lock_o after final beat", lock_o, 1'b0);
        check("R2", "mio_o after final beat", mio_o, 1'b0);
        check("R5", "cache_en_o at end", cache_en_o, exp_ken);
        check("R8", "wpolicy_o at end", wpolicy_o, wp);
        if (gap) begin
            rdy_i = 1; nxt_addr_i = 1; cache_en_i = !ken; wpolicy_i = !wp; par_en_i = 1;
            @(negedge clk);
            idle_inputs();
            check("R6", "cache_en_o after idle next-address", cache_en_o, exp_ken);
            check("R7", "wpolicy_o held while idle", wpolicy_o, wp);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1", "busy_o reset", busy_o, 1'b0);
        check("R1", "lock_o reset", lock_o, 1'b0);
        check("R1", "mio_o reset", mio_o, 1'b0);
        check("R1", "pcd_o reset", pcd_o, 1'b0);
        check("R1", "pwt_o reset", pwt_o, 1'b0);
        check("R1", "cache_en_o reset", cache_en_o, 1'b0);
        check("R1", "wpolicy_o reset", wpolicy_o, 1'b0);
        check("R1", "pchk_o reset", pchk_o, 1'b0);
        check("R1", "pchk_pen_o reset", pchk_pen_o, 1'b0);

        // single read, capture on first beat
        run_cycle(0, 0, 0, 0, 1, -1, 1, 1, 0, 1, 4'b0001);
        // burst read, early capture by next-address in second wait (R5, R6)
        run_cycle(0, 0, 1, 0, 3, 1, 1, 0, 0, 1, 4'b1010);
        // burst read, stray strobe mid-transaction (R4)
        run_cycle(0, 1, 1, 0, 2, -1, 0, 1, 1, 1, 4'b0110);
        // write burst: cache-enable ignored, no parity strobes (R5, R9)
        run_cycle(1, 0, 1, 0, 1, 0, 1, 1, 0, 1, 4'b1111);
        // single write, capture on beat
        run_cycle(1, 0, 0, 0, 0, -1, 1, 0, 0, 0, 4'b0001);
        // interrupt-acknowledge: pen only on second beat (R10)
        run_cycle(0, 0, 0, 1, 1, -1, 1, 1, 0, 1, 4'b0011);
        run_cycle(0, 0, 0, 1, 0, -1, 0, 0, 0, 1, 4'b0001);
        // back-to-back locked transactions (R11)
        run_cycle(0, 1, 0, 0, 0, -1, 1, 0, 0, 0, 4'b0001);
        check("R11", "lock_o low between locked transactions", lock_o, 1'b0);
        run_cycle(0, 1, 1, 0, 0, -1, 1, 1, 0, 0, 4'b0101);
        check("R11", "lock_o low between locked transactions", lock_o, 1'b0);
        run_cycle(1, 1, 0, 0, 1, 0, 0, 1, 0, 1, 4'b0000);

        repeat (4) @(negedge clk);
        check("R9", "scoreboard drained", sb_q.size() == 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule